// File: doc/BRIEF.md
# Serial Peripheral Run-State and Status Controller

This block is the control and status core of a serial bus peripheral. Software reaches it through a simple 32-bit register bus: a single-cycle write strobe with address and data, and combinational read data selected by the address. The block holds a two-bit operating state (reset, run, pause). A request to change that state is handshaked through a valid bit: valid drops while a fixed settling delay runs and rises again once the requested state is in effect. A software reset returns everything to its reset values at once, even in the middle of a transition.

The block keeps the operational flags for the datapath. FIFO empty and full levels are reported live. Service requests and a bus NACK are latched. Two transfer counters set done flags when they reach a programmed limit. Masked error flags are cleared by writing one to them. A level interrupt is raised from the enabled errors, the service flags and the latched NACK. Two strobes, `dp_run` and `dp_freeze`, tell the datapath to move data or to hold still while software loads it in pause. The serial engine and the FIFOs sit outside the block and are seen only as status and event inputs.

The sequencer has two states. SQ_STABLE is the state in which valid is high. SQ_SETTLE is the countdown in which valid is low. An accepted state write moves SQ_STABLE to SQ_SETTLE. SQ_SETTLE returns to SQ_STABLE when its countdown reaches zero, and the pending run state is loaded on that same edge. A software reset forces SQ_STABLE with run state RESET from either state.

Top module: `sercore_ctrl`

## Requirements
- R1: After reset, the state register (address 0x00) reads run state 0 (RESET) in bits [1:0] with valid (bit 2) high. The operational register (0x08) and the error register (0x0C) read zero when the datapath inputs are zero. `irq` and `dp_run` are low.
- R2: A write of 0 (RESET), 1 (RUN) or 3 (PAUSE) to bits [1:0] of 0x00 while valid is high drops valid on the next cycle. Valid stays low for exactly SETTLE_CYC cycles (default 6), then reads high with bits [1:0] equal to the requested value.
- R3: A state write with value 2, or any state write while valid is low, is ignored: the run state stays as it was, and the write does not extend a transition already in progress.
- R4: `dp_run` is high only when the run state is RUN and valid is high. `dp_freeze` is high when the run state is PAUSE or a transition is in progress. The two are never high together.
- R5: Writing 1 to bit 0 of 0x04 sets the run state to RESET with valid high on the next cycle, including mid-transition. It also clears the service, NACK, done and error flags and both transfer counters.
- R6: Bits 4, 5 and 6 of 0x08 mirror the `out_not_empty`, `in_not_empty` and `out_full` inputs. Bit 4 of 0x00 mirrors `mstr_ready`.
- R7: An `out_svc_req` or `in_svc_req` pulse sets bit 8 or bit 9 of 0x08. Writing 1 to that bit clears it. Writing 0 has no effect. A set and a clear in the same cycle leave the flag set.
- R8: A `nack_evt` pulse latches bit 3 of 0x08. Writing 1 to bit 3 clears it.
- R9: An `err_evt` pulse sets the bits of the error register 0x0C that lie in mask 0x7C. Bits outside the mask always read 0. Writing 1 to a bit of 0x0C clears it.
- R10: In state RUN with valid high, each `out_beat` (`in_beat`) pulse advances a counter. When the counter reaches the nonzero limit written at 0x14 (0x18), bit 10 (bit 11) of 0x08 sets and stays set until it is cleared by writing 1 to it. Beats outside RUN are ignored. A limit of 0 never sets the flag.
- R11: `irq` is high exactly while any of the following is set: an error flag whose enable bit at 0x10 is set, bit 8 or bit 9 of 0x08, or bit 3 of 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| mstr_ready | input | 1 | Serial master generated and ready |
| out_not_empty | input | 1 | Output FIFO holds data |
| in_not_empty | input | 1 | Input FIFO holds data |
| out_full | input | 1 | Output FIFO full |
| out_svc_req | input | 1 | Output service request pulse |
| in_svc_req | input | 1 | Input service request pulse |
| nack_evt | input | 1 | Bus NACK seen pulse |
| out_beat | input | 1 | One output entry transferred |
| in_beat | input | 1 | One input entry transferred |
| err_evt | input | 8 | Core error event pulses |
| dp_run | output | 1 | Datapath may move data |
| dp_freeze | output | 1 | Datapath must hold still |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is the short window in which valid is low. A second state write or a software reset that lands inside that window exercises R3 and R5. The bench issues the second write or the reset a fixed number of cycles after an accepted write, counted at the negative edge, and then checks both that the countdown was not restarted and that the final state is the one expected. The done flags also need the state to be RUN and stable. The bench therefore interleaves beats sent in PAUSE, which must be ignored, with beats sent in RUN, and counts the beats itself.

// File: rtl/sercore_pkg.sv
package sercore_pkg;
    typedef enum logic [1:0] {
        RS_RESET = 2'd0,
        RS_RUN   = 2'd1,
        RS_PAUSE = 2'd3
    } run_state_e;

    typedef enum logic {
        SQ_STABLE = 1'b0,
        SQ_SETTLE = 1'b1
    } seq_e;

    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] A_STATE  = 8'h00;
    localparam logic [ADDR_W-1:0] A_SWRST  = 8'h04;
    localparam logic [ADDR_W-1:0] A_OPFLG  = 8'h08;
    localparam logic [ADDR_W-1:0] A_ERRFLG = 8'h0C;
    localparam logic [ADDR_W-1:0] A_ERREN  = 8'h10;
    localparam logic [ADDR_W-1:0] A_OUTLIM = 8'h14;
    localparam logic [ADDR_W-1:0] A_INLIM  = 8'h18;

    localparam int B_NACK    = 3;
    localparam int B_OUT_NE  = 4;
    localparam int B_IN_NE   = 5;
    localparam int B_OUT_FUL = 6;
    localparam int B_OUT_SVC = 8;
    localparam int B_IN_SVC  = 9;
    localparam int B_OUT_DN  = 10;
    localparam int B_IN_DN   = 11;
endpackage

// File: rtl/sercore_state_seq.sv
module sercore_state_seq
    import sercore_pkg::*;
#(
    parameter int SETTLE_CYC = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sw_reset,
    input  logic       req_wr,
    input  logic [1:0] req_val,
    output run_state_e run_state,
    output logic       valid,
    output logic       dp_run,
    output logic       dp_freeze
);
    localparam int SETL_W = $clog2(SETTLE_CYC + 1);

    seq_e              seq_q;
    run_state_e        pend_q;
    logic [SETL_W-1:0] cnt_q;
    logic              accept;

    assign accept = req_wr && (seq_q == SQ_STABLE) && (req_val != 2'b10);

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q     <= SQ_STABLE;
            run_state <= RS_RESET;
            pend_q    <= RS_RESET;
            cnt_q     <= '0;
        end else if (sw_reset) begin
            seq_q     <= SQ_STABLE;
            run_state <= RS_RESET;
            pend_q    <= RS_RESET;
            cnt_q     <= '0;
        end else begin
            unique case (seq_q)
                SQ_STABLE: begin
                    if (accept) begin
                        seq_q  <= SQ_SETTLE;
                        pend_q <= run_state_e'(req_val);
                        cnt_q  <= SETL_W'(SETTLE_CYC - 1);
                    end
                end
                SQ_SETTLE: begin
                    if (cnt_q == '0) begin
                        seq_q     <= SQ_STABLE;
                        run_state <= pend_q;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: seq_q <= SQ_STABLE;
            endcase
        end
    end

    // Output process
    always_comb begin
        valid     = (seq_q == SQ_STABLE);
        dp_run    = valid && (run_state == RS_RUN);
        dp_freeze = !valid || (run_state == RS_PAUSE);
    end

    AST_ACCEPT_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !sw_reset) |=> !valid); // R2
    AST_VALID_RISE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(valid) && !$past(sw_reset)) |-> (run_state == pend_q)); // R2
    AST_NO_ILLEGAL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (2'(run_state) != 2'b10)); // R3
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && !valid && !sw_reset && cnt_q != '0) |=> (!valid && $stable(pend_q))); // R3
    AST_SWRST_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (valid && run_state == RS_RESET)); // R5
    AST_RUN_FREEZE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dp_run && dp_freeze)); // R4
endmodule

// File: rtl/sercore_opflags.sv
module sercore_opflags
    import sercore_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_reset,
    input  logic             run_active,
    input  logic             run_is_reset,
    input  logic             wr_op,
    input  logic [11:0]      wdata_op,
    input  logic [1:0]       lim_wr,
    input  logic [CNT_W-1:0] lim_wdata,
    input  logic             out_svc_req,
    input  logic             in_svc_req,
    input  logic             nack_evt,
    input  logic [1:0]       beat,
    output logic             out_svc,
    output logic             in_svc,
    output logic             nack,
    output logic [1:0]       done,
    output logic [1:0][CNT_W-1:0] lim
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_svc <= 1'b0;
            in_svc  <= 1'b0;
            nack    <= 1'b0;
        end else if (sw_reset) begin
            out_svc <= 1'b0;
            in_svc  <= 1'b0;
            nack    <= 1'b0;
        end else begin
            if (out_svc_req)                     out_svc <= 1'b1;
            else if (wr_op && wdata_op[B_OUT_SVC]) out_svc <= 1'b0;
            if (in_svc_req)                      in_svc <= 1'b1;
            else if (wr_op && wdata_op[B_IN_SVC])  in_svc <= 1'b0;
            if (nack_evt)                        nack <= 1'b1;
            else if (wr_op && wdata_op[B_NACK])    nack <= 1'b0;
        end
    end

    // One transfer counter channel per direction: 0 = output, 1 = input
    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        logic [CNT_W-1:0] cnt_q;
        logic             hit;
        logic             clr_bit;

        assign hit     = beat[ch] && run_active && (lim[ch] != '0) && (cnt_q + ONE == lim[ch]);
        assign clr_bit = wr_op && wdata_op[B_OUT_DN + ch];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lim[ch] <= '0;
            end else if (lim_wr[ch]) begin
                lim[ch] <= lim_wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q    <= '0;
                done[ch] <= 1'b0;
            end else if (sw_reset) begin
                cnt_q    <= '0;
                done[ch] <= 1'b0;
            end else begin
                if (run_is_reset || lim_wr[ch])
                    cnt_q <= '0;
                else if (beat[ch] && run_active && cnt_q != lim[ch])
                    cnt_q <= cnt_q + ONE;
                if (hit)          done[ch] <= 1'b1;
                else if (clr_bit) done[ch] <= 1'b0;
            end
        end

        AST_DONE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(done[ch]) |-> $past(run_active)); // R10
    end
endmodule

// File: rtl/sercore_errflags.sv
module sercore_errflags #(
    parameter int              ERR_W    = 8,
    parameter logic [ERR_W-1:0] ERR_MASK = 8'h7C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_reset,
    input  logic             wr_clr,
    input  logic             wr_en,
    input  logic [ERR_W-1:0] wdata,
    input  logic [ERR_W-1:0] err_evt,
    output logic [ERR_W-1:0] flags,
    output logic [ERR_W-1:0] enable,
    output logic             err_irq
);
    logic [ERR_W-1:0] clr_mask;
    assign clr_mask = wr_clr ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (sw_reset) begin
            flags <= '0;
        end else begin
            flags <= ((flags & ~clr_mask) | err_evt) & ERR_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     enable <= '0;
        else if (wr_en) enable <= wdata;
    end

    assign err_irq = |(flags & enable);

    AST_ERR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~ERR_MASK) == '0)); // R9
    AST_ERR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !sw_reset && ((wdata & ~err_evt) != '0)) |=> ((flags & $past(wdata & ~err_evt)) == '0)); // R9
endmodule

// File: rtl/sercore_ctrl.sv
module sercore_ctrl
    import sercore_pkg::*;
#(
    parameter int SETTLE_CYC = 6,
    parameter int CNT_W      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        mstr_ready,
    input  logic        out_not_empty,
    input  logic        in_not_empty,
    input  logic        out_full,
    input  logic        out_svc_req,
    input  logic        in_svc_req,
    input  logic        nack_evt,
    input  logic        out_beat,
    input  logic        in_beat,
    input  logic [7:0]  err_evt,
    output logic        dp_run,
    output logic        dp_freeze,
    output logic        irq
);
    run_state_e run_state;
    logic       valid;
    logic       sw_reset;
    logic       out_svc, in_svc, nack;
    logic [1:0] done;
    logic [1:0][CNT_W-1:0] lim;
    logic [7:0] err_flags, err_en;
    logic       err_irq;
    logic       unused_wbits;

    assign unused_wbits = ^bus_wdata[31:CNT_W];
    assign sw_reset     = bus_wr && (bus_addr == A_SWRST) && bus_wdata[0];

    sercore_state_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_reset  (sw_reset),
        .req_wr    (bus_wr && (bus_addr == A_STATE)),
        .req_val   (bus_wdata[1:0]),
        .run_state (run_state),
        .valid     (valid),
        .dp_run    (dp_run),
        .dp_freeze (dp_freeze)
    );

    sercore_opflags #(.CNT_W(CNT_W)) u_op (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_reset     (sw_reset),
        .run_active   (dp_run),
        .run_is_reset (run_state == RS_RESET),
        .wr_op        (bus_wr && (bus_addr == A_OPFLG)),
        .wdata_op     (bus_wdata[11:0]),
        .lim_wr       ({bus_wr && (bus_addr == A_INLIM), bus_wr && (bus_addr == A_OUTLIM)}),
        .lim_wdata    (bus_wdata[CNT_W-1:0]),
        .out_svc_req  (out_svc_req),
        .in_svc_req   (in_svc_req),
        .nack_evt     (nack_evt),
        .beat         ({in_beat, out_beat}),
        .out_svc      (out_svc),
        .in_svc       (in_svc),
        .nack         (nack),
        .done         (done),
        .lim          (lim)
    );

    sercore_errflags #(.ERR_W(8), .ERR_MASK(8'h7C)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_reset(sw_reset),
        .wr_clr  (bus_wr && (bus_addr == A_ERRFLG)),
        .wr_en   (bus_wr && (bus_addr == A_ERREN)),
        .wdata   (bus_wdata[7:0]),
        .err_evt (err_evt),
        .flags   (err_flags),
        .enable  (err_en),
        .err_irq (err_irq)
    );

    assign irq = err_irq || out_svc || in_svc || nack;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_STATE: begin
                bus_rdata[1:0] = run_state;
                bus_rdata[2]   = valid;
                bus_rdata[4]   = mstr_ready;
            end
            A_OPFLG: begin
                bus_rdata[B_NACK]    = nack;
                bus_rdata[B_OUT_NE]  = out_not_empty;
                bus_rdata[B_IN_NE]   = in_not_empty;
                bus_rdata[B_OUT_FUL] = out_full;
                bus_rdata[B_OUT_SVC] = out_svc;
                bus_rdata[B_IN_SVC]  = in_svc;
                bus_rdata[B_OUT_DN]  = done[0];
                bus_rdata[B_IN_DN]   = done[1];
            end
            A_ERRFLG: bus_rdata[7:0]       = err_flags;
            A_ERREN:  bus_rdata[7:0]       = err_en;
            A_OUTLIM: bus_rdata[CNT_W-1:0] = lim[0];
            A_INLIM:  bus_rdata[CNT_W-1:0] = lim[1];
            default:  bus_rdata = '0;
        endcase
    end

    AST_IRQ_FROM_SVC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rdata[B_OUT_SVC] && bus_addr == A_OPFLG && $stable(bus_addr)) |-> irq); // R11
    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_svc && !in_svc && !nack && ((err_flags & err_en) == '0)) |-> !irq); // R11
endmodule

// File: tb/sim_sercore_ctrl.sv
`timescale 1ns/1ps
module sim_sercore_ctrl;
    localparam int SETTLE = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mstr_ready = 1'b0, out_not_empty = 1'b0, in_not_empty = 1'b0, out_full = 1'b0;
    logic        out_svc_req = 1'b0, in_svc_req = 1'b0, nack_evt = 1'b0;
    logic        out_beat = 1'b0, in_beat = 1'b0;
    logic [7:0]  err_evt = '0;
    logic        dp_run, dp_freeze, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit ended = 0;

    always #2 clk = ~clk;

    sercore_ctrl #(.SETTLE_CYC(SETTLE), .CNT_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mstr_ready(mstr_ready),
        .out_not_empty(out_not_empty), .in_not_empty(in_not_empty), .out_full(out_full),
        .out_svc_req(out_svc_req), .in_svc_req(in_svc_req), .nack_evt(nack_evt),
        .out_beat(out_beat), .in_beat(in_beat), .err_evt(err_evt),
        .dp_run(dp_run), .dp_freeze(dp_freeze), .irq(irq)
    );

    // Vector table: {requested value, expected state after settle, accepted}
    localparam int NV = 8;
    localparam logic [4:0] VEC [NV] = '{
        {2'd1, 2'd1, 1'b1}, {2'd3, 2'd3, 1'b1}, {2'd2, 2'd3, 1'b0}, {2'd1, 2'd1, 1'b1},
        {2'd2, 2'd1, 1'b0}, {2'd0, 2'd0, 1'b1}, {2'd3, 2'd3, 1'b1}, {2'd0, 2'd0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_out_svc(); @(negedge clk); out_svc_req = 1; @(negedge clk); out_svc_req = 0; endtask
    task automatic pulse_nack();    @(negedge clk); nack_evt = 1;    @(negedge clk); nack_evt = 0;    endtask
    task automatic pulse_err(input logic [7:0] e); @(negedge clk); err_evt = e; @(negedge clk); err_evt = '0; endtask
    task automatic pulse_beat(input bit isin);
        @(negedge clk);
        if (isin) in_beat = 1; else out_beat = 1;
        @(negedge clk);
        in_beat = 0; out_beat = 0;
    endtask

    task automatic go_state(input logic [1:0] s);
        wr(8'h00, {30'd0, s});
        idle(SETTLE);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] d;
        idle(2);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(8'h00, d); chk("R1 state reg", d, 32'h4);
        rd(8'h08, d); chk("R1 op reg", d, 32'h0);
        rd(8'h0C, d); chk("R1 err reg", d, 32'h0);
        chk("R1 irq/dp_run", {30'd0, irq, dp_run}, 32'h0);

        // R2 R3 R4 vector walk
        for (int v = 0; v < NV; v++) begin
            logic [1:0] req, exp;
            logic acc;
            {req, exp, acc} = VEC[v];
            wr(8'h00, {30'd0, req});
            rd(8'h00, d);
            chk(acc ? "R2 valid drops" : "R3 illegal ignored", {31'd0, d[2]}, {31'd0, !acc});
            if (acc) begin
                chk("R4 freeze in settle", {30'd0, dp_run, dp_freeze}, 32'h1);
                idle(SETTLE - 1);
                rd(8'h00, d);
                chk("R2 still settling", {31'd0, d[2]}, 32'h0);
                idle(1);
            end
            rd(8'h00, d);
            chk("R2 landed state", {29'd0, d[2:0]}, {29'd0, 1'b1, exp});
            chk("R4 strobes", {30'd0, dp_run, dp_freeze}, {30'd0, exp == 2'd1, exp == 2'd3});
        end

        // R3 write during settle ignored and does not extend
        wr(8'h00, 32'h1);
        idle(1);
        wr(8'h00, 32'h3);
        idle(SETTLE - 3);
        rd(8'h00, d);
        chk("R3 busy write ignored", {29'd0, d[2:0]}, 32'h5);

        // R6 live mirrors
        mstr_ready = 1; out_not_empty = 1; in_not_empty = 0; out_full = 1;
        rd(8'h08, d); chk("R6 op live bits", d & 32'h70, 32'h50);
        rd(8'h00, d); chk("R6 master ready", {31'd0, d[4]}, 32'h1);
        out_not_empty = 0; out_full = 0; in_not_empty = 1;
        rd(8'h08, d); chk("R6 op live bits 2", d & 32'h70, 32'h20);
        in_not_empty = 0;

        // R7 service flags
        pulse_out_svc();
        rd(8'h08, d); chk("R7 out svc set", d & 32'h300, 32'h100);
        chk("R11 irq svc", {31'd0, irq}, 32'h1);
        wr(8'h08, 32'h0);
        rd(8'h08, d); chk("R7 zero write no effect", d & 32'h300, 32'h100);
        @(negedge clk); bus_addr = 8'h08; bus_wdata = 32'h100; bus_wr = 1; out_svc_req = 1;
        @(negedge clk); bus_wr = 0; out_svc_req = 0;
        rd(8'h08, d); chk("R7 set wins", d & 32'h100, 32'h100);
        wr(8'h08, 32'h100);
        rd(8'h08, d); chk("R7 w1c", d & 32'h300, 32'h0);
        @(negedge clk); in_svc_req = 1; @(negedge clk); in_svc_req = 0;
        rd(8'h08, d); chk("R7 in svc set", d & 32'h300, 32'h200);
        wr(8'h08, 32'h200);
        chk("R11 irq clear", {31'd0, irq}, 32'h0);

        // R8 nack
        pulse_nack();
        rd(8'h08, d); chk("R8 nack latched", d & 32'h8, 32'h8);
        chk("R11 irq nack", {31'd0, irq}, 32'h1);
        wr(8'h08, 32'h8);
        rd(8'h08, d); chk("R8 nack w1c", d & 32'h8, 32'h0);

        // R9 R11 error flags
        pulse_err(8'h83);
        rd(8'h0C, d); chk("R9 outside mask", d, 32'h0);
        pulse_err(8'h24);
        rd(8'h0C, d); chk("R9 masked set", d, 32'h24);
        chk("R11 disabled err", {31'd0, irq}, 32'h0);
        wr(8'h10, 32'h04);
        chk("R11 enabled err", {31'd0, irq}, 32'h1);
        wr(8'h0C, 32'h04);
        rd(8'h0C, d); chk("R9 w1c", d, 32'h20);
        chk("R11 irq after clear", {31'd0, irq}, 32'h0);

        // R10 done flags (state currently RUN)
        wr(8'h14, 32'd3);
        go_state(2'd3);
        pulse_beat(0); pulse_beat(0); pulse_beat(0);
        rd(8'h08, d); chk("R10 beats in pause ignored", d & 32'hC00, 32'h0);
        go_state(2'd1);
        pulse_beat(0); pulse_beat(0);
        rd(8'h08, d); chk("R10 below limit", d & 32'hC00, 32'h0);
        pulse_beat(0);
        rd(8'h08, d); chk("R10 out done", d & 32'hC00, 32'h400);
        pulse_beat(1);
        rd(8'h08, d); chk("R10 zero limit", d & 32'h800, 32'h0);
        wr(8'h18, 32'd1);
        pulse_beat(1);
        rd(8'h08, d); chk("R10 in done", d & 32'hC00, 32'hC00);
        wr(8'h08, 32'h400);
        rd(8'h08, d); chk("R10 done w1c", d & 32'hC00, 32'h800);

        // R5 software reset mid-transition clears flags
        pulse_out_svc();
        pulse_err(8'h10);
        wr(8'h00, 32'h3);
        idle(1);
        wr(8'h04, 32'h1);
        rd(8'h00, d); chk("R5 state home", {29'd0, d[2:0]}, 32'h4);
        rd(8'h08, d); chk("R5 op cleared", d, 32'h0);
        rd(8'h0C, d); chk("R5 err cleared", d, 32'h0);
        chk("R5 irq low", {31'd0, irq}, 32'h0);
        idle(SETTLE + 2);
        rd(8'h00, d); chk("R5 no late landing", {29'd0, d[2:0]}, 32'h4);

        summary();
    end
endmodule